// File: doc/BRIEF.md
# Serial Synthesizer Configuration Port

This block is the programming port of a two-channel frequency synthesizer. Software, through an external controller, drives three slow serial wires: a shift clock, a data line and a latch strobe. All three are first synchronized to the system clock. The block then finds their rising edges and moves each data bit into a 22-bit shift register. A rising edge on the latch strobe copies the assembled word into one of four control banks. The two lowest bits of the word select the bank.

Two banks hold the divider settings for each channel. One holds the reference divide value and half of the observation select. The other holds the swallow count, the main count and the prescaler modulus bit. The latched fields drive the synthesizer's counters directly. One output, `obsOut`, shows one of several internal divider and lock signals, as chosen by the four observation select bits.

Top module: `serial_cfg_port`

## Requirements
- R1: Each rising edge of `serClk`, after a two-flop synchronizer, shifts the synchronized `serData` value into bit 0 of a 22-bit shift register. The older bits move one place toward bit 21.
- R2: Words are sent most significant bit first. The first of 22 bits sent lands in word bit 21.
- R3: Only a rising edge of `serLatch` changes a bank. Shifting bits without a strobe leaves every output field unchanged.
- R4: Word bits [1:0] pick the destination bank: 00 = channel-2 reference bank, 01 = channel-2 count bank, 10 = channel-1 reference bank, 11 = channel-1 count bank. The other three banks keep their contents.
- R5: In a reference bank, word bits [15:2] are the 14-bit reference divide value and bits [17:16] are two observation select bits.
- R6: In a count bank, bits [7:2] are the 6-bit swallow count A, bits [18:8] are the 11-bit main count B, and bit 20 is the prescaler select (1 = 64/65, 0 = 32/33).
- R7: When more than 22 bits are shifted before a strobe, only the last 22 bits sent are latched.
- R8: The observation select code is {channel-1 bits [17:16], channel-2 bits [17:16]}, a 4-bit value. It picks `obsOut` as follows: 1 = `obsSrc[0]` (ch1 reference tick), 2 = `obsSrc[1]` (ch1 feedback tick), 3 = `obsSrc[2]` (ch1 lock), 4 = `obsSrc[3]`, 5 = `obsSrc[4]`, 6 = `obsSrc[5]` (the same three for ch2), 7 = `obsSrc[2] & obsSrc[5]`. Code 0 and codes 8 to 15 drive low.
- R9: After reset every bank is zero, so every field output is zero and `obsOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial shift clock (asynchronous) |
| serData | input | 1 | Serial data, MSB first |
| serLatch | input | 1 | Latch strobe, rising edge transfers the word |
| obsSrc | input | 6 | Observable signals: ch1 ref, ch1 fb, ch1 lock, ch2 ref, ch2 fb, ch2 lock |
| ch1RefDiv | output | 14 | Channel-1 reference divide value |
| ch1SwallowA | output | 6 | Channel-1 A count |
| ch1MainB | output | 11 | Channel-1 B count |
| ch1PreSel | output | 1 | Channel-1 prescaler modulus select |
| ch2RefDiv | output | 14 | Channel-2 reference divide value |
| ch2SwallowA | output | 6 | Channel-2 A count |
| ch2MainB | output | 11 | Channel-2 B count |
| ch2PreSel | output | 1 | Channel-2 prescaler modulus select |
| obsOut | output | 1 | Observation multiplexer output |

## Verification
Assertions check on every cycle that each detected edge is a single-cycle strobe and that the shift register holds when no shift strobe is present. They also check that a shift moves the word up by exactly one place and that a bank changes only when a latch strobe addresses it, in which case it takes the shift register value. Assertions also keep the observation output low for the idle code. Only the bench's scenarios can show the end-to-end results: that MSB-first ordering places each field at its documented bit position, that overlong bursts keep only the trailing 22 bits, that each of the four control codes reaches the right channel outputs, and that the observation table maps every code to the right source.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  parameter int WORD_W = 22;
  parameter int CTL_W = 2;
  parameter int NUM_BANKS = 1 << CTL_W;
  parameter int R_W = 14;
  parameter int A_W = 6;
  parameter int B_W = 11;
  parameter int SEL_W = 2;
  parameter int OBS_SRC_W = 6;

  // field positions inside a latched word
  parameter int R_LSB = CTL_W;
  parameter int SEL_LSB = R_LSB + R_W;
  parameter int A_LSB = CTL_W;
  parameter int B_LSB = A_LSB + A_W;
  parameter int PRE_BIT = 20;

  // bank indices addressed by the control bits
  parameter int BANK_CH2_REF = 0;
  parameter int BANK_CH2_CNT = 1;
  parameter int BANK_CH1_REF = 2;
  parameter int BANK_CH1_CNT = 3;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic latchEn;
  } cfg_strobe_t;
endpackage

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serLatch,
  output cfg_strobe_t strobe
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] clkSync, dataSync, latchSync;
  logic clkPrev, latchPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync   <= '0;
      dataSync  <= '0;
      latchSync <= '0;
      clkPrev   <= 1'b0;
      latchPrev <= 1'b0;
    end else begin
      clkSync   <= {clkSync[TOP-1:0], serClk};
      dataSync  <= {dataSync[TOP-1:0], serData};
      latchSync <= {latchSync[TOP-1:0], serLatch};
      clkPrev   <= clkSync[TOP];
      latchPrev <= latchSync[TOP];
    end
  end

  always_comb begin
    strobe.shiftEn  = clkSync[TOP] & ~clkPrev;
    strobe.shiftBit = dataSync[TOP];
    strobe.latchEn  = latchSync[TOP] & ~latchPrev;
  end

  // R1: a detected shift edge lasts one cycle
  p_shift_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> !strobe.shiftEn);
  // R3: a detected latch edge lasts one cycle
  p_latch_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchEn |=> !strobe.latchEn);
endmodule

// File: rtl/cfg_port_dp.sv
module cfg_port_dp
  import cfg_port_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  cfg_strobe_t          strobe,
  input  logic [OBS_SRC_W-1:0] obsSrc,
  output logic [R_W-1:0]       ch1RefDiv,
  output logic [A_W-1:0]       ch1SwallowA,
  output logic [B_W-1:0]       ch1MainB,
  output logic                 ch1PreSel,
  output logic [R_W-1:0]       ch2RefDiv,
  output logic [A_W-1:0]       ch2SwallowA,
  output logic [B_W-1:0]       ch2MainB,
  output logic                 ch2PreSel,
  output logic                 obsOut
);
  localparam int OBS_SEL_W = 2 * SEL_W;

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] bank [NUM_BANKS];
  logic [CTL_W-1:0]  dest;
  logic [OBS_SEL_W-1:0] obsSel;

  assign dest = shiftReg[CTL_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], strobe.shiftBit};
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bank[i] <= '0;
      else if (strobe.latchEn && dest == CTL_W'(i)) bank[i] <= shiftReg;
    end

    // R3, R4: a bank changes only when a strobe addresses it
    p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
      !(strobe.latchEn && dest == CTL_W'(i)) |=> $stable(bank[i]));
    // R4: the addressed bank takes the assembled word
    p_bank_load_r4: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.latchEn && dest == CTL_W'(i)) |=> bank[i] == $past(shiftReg));
  end

  assign ch1RefDiv   = bank[BANK_CH1_REF][R_LSB +: R_W];
  assign ch2RefDiv   = bank[BANK_CH2_REF][R_LSB +: R_W];
  assign ch1SwallowA = bank[BANK_CH1_CNT][A_LSB +: A_W];
  assign ch2SwallowA = bank[BANK_CH2_CNT][A_LSB +: A_W];
  assign ch1MainB    = bank[BANK_CH1_CNT][B_LSB +: B_W];
  assign ch2MainB    = bank[BANK_CH2_CNT][B_LSB +: B_W];
  assign ch1PreSel   = bank[BANK_CH1_CNT][PRE_BIT];
  assign ch2PreSel   = bank[BANK_CH2_CNT][PRE_BIT];
  assign obsSel = {bank[BANK_CH1_REF][SEL_LSB +: SEL_W],
                   bank[BANK_CH2_REF][SEL_LSB +: SEL_W]};

  always_comb begin
    case (obsSel)
      4'd1:    obsOut = obsSrc[0];
      4'd2:    obsOut = obsSrc[1];
      4'd3:    obsOut = obsSrc[2];
      4'd4:    obsOut = obsSrc[3];
      4'd5:    obsOut = obsSrc[4];
      4'd6:    obsOut = obsSrc[5];
      4'd7:    obsOut = obsSrc[2] & obsSrc[5];
      default: obsOut = 1'b0;
    endcase
  end

  // R1: no shift strobe, no change to the shift register
  p_shift_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(shiftReg));
  // R2: a shift moves the word one place toward the MSB
  p_shift_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> shiftReg[WORD_W-1:1] == $past(shiftReg[WORD_W-2:0]));
  // R8: idle and unused codes keep the observation output low
  p_obs_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (obsSel == '0 || obsSel[OBS_SEL_W-1]) |-> !obsOut);
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import cfg_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serClk,
  input  logic                 serData,
  input  logic                 serLatch,
  input  logic [OBS_SRC_W-1:0] obsSrc,
  output logic [R_W-1:0]       ch1RefDiv,
  output logic [A_W-1:0]       ch1SwallowA,
  output logic [B_W-1:0]       ch1MainB,
  output logic                 ch1PreSel,
  output logic [R_W-1:0]       ch2RefDiv,
  output logic [A_W-1:0]       ch2SwallowA,
  output logic [B_W-1:0]       ch2MainB,
  output logic                 ch2PreSel,
  output logic                 obsOut
);
  cfg_strobe_t strobe;

  cfg_port_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .strobe(strobe)
  );

  cfg_port_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .obsSrc(obsSrc),
    .ch1RefDiv(ch1RefDiv), .ch1SwallowA(ch1SwallowA), .ch1MainB(ch1MainB),
    .ch1PreSel(ch1PreSel), .ch2RefDiv(ch2RefDiv), .ch2SwallowA(ch2SwallowA),
    .ch2MainB(ch2MainB), .ch2PreSel(ch2PreSel), .obsOut(obsOut)
  );
endmodule

// File: tb/serial_cfg_port_test.sv
module serial_cfg_port_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLatch = 1'b0;
  logic [5:0] obsSrc = '0;
  logic [13:0] ch1RefDiv, ch2RefDiv;
  logic [5:0]  ch1SwallowA, ch2SwallowA;
  logic [10:0] ch1MainB, ch2MainB;
  logic ch1PreSel, ch2PreSel, obsOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_cfg_port uut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .obsSrc(obsSrc),
    .ch1RefDiv(ch1RefDiv), .ch1SwallowA(ch1SwallowA), .ch1MainB(ch1MainB),
    .ch1PreSel(ch1PreSel), .ch2RefDiv(ch2RefDiv), .ch2SwallowA(ch2SwallowA),
    .ch2MainB(ch2MainB), .ch2PreSel(ch2PreSel), .obsOut(obsOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic sendBits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      serData = bits[i];
      waitClk(3);
      serClk = 1'b1;
      waitClk(3);
      serClk = 1'b0;
      waitClk(3);
    end
  endtask

  task automatic pulseLatch();
    serLatch = 1'b1;
    waitClk(4);
    serLatch = 1'b0;
    waitClk(4);
    @(negedge clk);
  endtask

  task automatic sendWord(input logic [21:0] w);
    sendBits({10'b0, w}, 22);
    pulseLatch();
  endtask

  function automatic logic [21:0] refWord(input logic [1:0] sel, input logic [13:0] r, input logic [1:0] ctl);
    return {4'b0, sel, r, ctl};
  endfunction

  function automatic logic [21:0] cntWord(input logic pre, input logic [10:0] b, input logic [5:0] a, input logic [1:0] ctl);
    return {1'b0, pre, 1'b0, b, a, ctl};
  endfunction

  function automatic logic obsExp(input logic [3:0] code, input logic [5:0] s);
    case (code)
      4'd1: return s[0];
      4'd2: return s[1];
      4'd3: return s[2];
      4'd4: return s[3];
      4'd5: return s[4];
      4'd6: return s[5];
      4'd7: return s[2] & s[5];
      default: return 1'b0;
    endcase
  endfunction

  task automatic testReset();
    @(negedge clk);
    check("R9 ch1RefDiv", 32'(ch1RefDiv), 0);
    check("R9 ch2RefDiv", 32'(ch2RefDiv), 0);
    check("R9 ch1 counts", {ch1PreSel, ch1MainB, ch1SwallowA}, 0);
    check("R9 ch2 counts", {ch2PreSel, ch2MainB, ch2SwallowA}, 0);
    obsSrc = 6'h3f;
    #1;
    check("R9 obsOut", 32'(obsOut), 0);
    obsSrc = '0;
  endtask

  task automatic testRefBanks();
    sendWord(refWord(2'b00, 14'h3fff, 2'b10));
    check("R5 ch1RefDiv max", 32'(ch1RefDiv), 32'h3fff);
    check("R4 ch2RefDiv untouched", 32'(ch2RefDiv), 0);
    sendWord(refWord(2'b00, 14'h0001, 2'b00));
    check("R5 ch2RefDiv min", 32'(ch2RefDiv), 1);
    check("R4 ch1RefDiv kept", 32'(ch1RefDiv), 32'h3fff);
    check("R4 counts untouched", {ch1MainB, ch2MainB}, 0);
  endtask

  task automatic testCountBanks();
    sendWord(cntWord(1'b1, 11'h5a3, 6'h2d, 2'b11));
    check("R6 ch1SwallowA", 32'(ch1SwallowA), 32'h2d);
    check("R2 R6 ch1MainB", 32'(ch1MainB), 32'h5a3);
    check("R6 ch1PreSel", 32'(ch1PreSel), 1);
    check("R4 ch2 count untouched", {ch2PreSel, ch2MainB, ch2SwallowA}, 0);
    sendWord(cntWord(1'b0, 11'h001, 6'h3f, 2'b01));
    check("R6 ch2SwallowA", 32'(ch2SwallowA), 32'h3f);
    check("R2 ch2MainB", 32'(ch2MainB), 1);
    check("R6 ch2PreSel", 32'(ch2PreSel), 0);
    check("R4 ch1 count kept", {ch1PreSel, ch1MainB, ch1SwallowA}, {1'b1, 11'h5a3, 6'h2d});
    check("R4 refs kept", {ch1RefDiv, ch2RefDiv}, {14'h3fff, 14'h0001});
  endtask

  task automatic testNoLatch();
    sendBits({10'b0, cntWord(1'b0, 11'h7ff, 6'h00, 2'b11)}, 22);
    waitClk(8);
    @(negedge clk);
    check("R3 ch1MainB held", 32'(ch1MainB), 32'h5a3);
    check("R3 ch1PreSel held", 32'(ch1PreSel), 1);
    check("R1 R3 ch1SwallowA held", 32'(ch1SwallowA), 32'h2d);
    pulseLatch();
    check("R1 ch1MainB after strobe", 32'(ch1MainB), 32'h7ff);
  endtask

  task automatic testOverlong();
    sendBits(32'h1f, 5);
    sendWord(refWord(2'b00, 14'h2a55, 2'b10));
    check("R7 ch1RefDiv trailing bits", 32'(ch1RefDiv), 32'h2a55);
    sendBits(32'h155, 9);
    sendWord(cntWord(1'b1, 11'h123, 6'h15, 2'b01));
    check("R7 ch2 count trailing bits", {ch2PreSel, ch2MainB, ch2SwallowA}, {1'b1, 11'h123, 6'h15});
  endtask

  task automatic testObs();
    for (int code = 0; code < 16; code++) begin
      sendWord(refWord(code[3:2], 14'h0010, 2'b10));
      sendWord(refWord(code[1:0], 14'h0020, 2'b00));
      for (int p = 0; p < 3; p++) begin
        logic [5:0] s;
        s = (p == 0) ? 6'b101010 : (p == 1) ? 6'b010101 : 6'b100100;
        obsSrc = s;
        #1;
        check($sformatf("R8 obs code %0d pattern %0d", code, p), 32'(obsOut), 32'(obsExp(code[3:0], s)));
      end
      obsSrc = '0;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    waitClk(3);
    testReset();
    rstN = 1'b1;
    waitClk(2);
    testReset();
    testRefBanks();
    testCountBanks();
    testNoLatch();
    testOverlong();
    testObs();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule